// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the head of an instruction decoder. It takes the bytes of a variable-length instruction one per cycle and sorts every leading prefix byte into one of four groups: lock/repeat, segment override, operand-size override and address-size override. For each group it keeps only the prefix that is currently in force. When the first byte that is not a prefix arrives, the block treats that byte as the opcode. One cycle later it issues a single result beat. The beat carries the resolved group codes, the two override flags, the effective operand and address sizes, the number of prefixes and the opcode byte.

A mode input gives the default operand and address size for each instruction. An override flips the matching size to the other of 16 and 32 bits. The architectural length limit is 15 bytes. If that many prefix bytes arrive with no opcode, no opcode could still fit. The block then raises a one-cycle length fault, drops the instruction and starts the next one from an empty state.

Top module: `prefix_scanner`

## Requirements
- R1: The lock/repeat group codes are F0h → 1 (lock), F2h → 2 (repeat while not equal) and F3h → 3 (repeat while equal). The value 0 means no prefix from this group. The code appears on `out_grp1`.
- R2: The segment group codes are 26h → 1, 2Eh → 2, 36h → 3, 3Eh → 4, 64h → 5 and 65h → 6. The value 0 means no segment prefix. The code appears on `out_grp2`.
- R3: Byte 66h sets `out_opsz_ovr` and byte 67h sets `out_adsz_ovr`. Every byte outside the eleven prefix codes ends the prefix phase and is taken as the opcode.
- R4: Prefixes from different groups are accepted in any order. Each group's result does not depend on where that group's prefix sits relative to the others.
- R5: When several prefixes of the lock/repeat group or of the segment group arrive, the last one received is reported. Earlier ones in the same group leave no trace.
- R6: Repeating 66h or 67h gives the same flag as a single occurrence. A repeat never cancels an override.
- R7: `out_op32` equals `mode_op32` XOR `out_opsz_ovr`, and `out_ad32` equals `mode_ad32` XOR `out_adsz_ovr`. The mode inputs are sampled in the cycle the opcode byte is taken.
- R8: The cycle after an opcode byte is taken, `out_valid` is high for exactly one cycle. In that cycle `out_opcode` holds the byte and `out_count` holds the number of prefixes before it (0 to 14).
- R9: When a 15th prefix byte is taken for one instruction, `out_fault` is high for one cycle in the following cycle. No result beat is issued for that instruction. `out_valid` and `out_fault` are never high together.
- R10: After a result beat or a fault, every group returns to "none" and the prefix count returns to 0 before the next byte.
- R11: `in_ready` is always high. A cycle with `in_valid` low changes no state. After reset, `out_valid`, `out_fault` and `out_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can take a byte (always high) |
| mode_op32 | input | 1 | Default operand size is 32 bits when high, else 16 |
| mode_ad32 | input | 1 | Default address size is 32 bits when high, else 16 |
| out_valid | output | 1 | One-cycle result beat |
| out_fault | output | 1 | One-cycle length fault |
| out_grp1 | output | 2 | Lock/repeat group code |
| out_grp2 | output | 3 | Segment group code |
| out_opsz_ovr | output | 1 | Operand-size override present |
| out_adsz_ovr | output | 1 | Address-size override present |
| out_op32 | output | 1 | Effective operand size is 32 bits |
| out_ad32 | output | 1 | Effective address size is 32 bits |
| out_count | output | 4 | Number of prefix bytes |
| out_opcode | output | 8 | First non-prefix byte |

## Verification
The assertions check four behaviours on every cycle:
- A newly taken prefix overwrites its group's state.
- The effective sizes agree with the sampled mode and the override flags.
- Each result beat carries the byte taken one cycle before, and each fault follows a 15th prefix.
- State is empty whenever a beat or a fault appears, and beat and fault never coincide.

The bench scenarios show the rest:
- whole-instruction results for every byte value;
- every ordered pair of prefixes;
- every mode and override combination;
- idle gaps inside an instruction;
- prefix runs across the length limit, including the instruction that follows a fault.

// File: rtl/pfx_pkg.sv
// Package: shared encodings for the prefix scanner.
// Assumes four prefix groups, each holding a small nonzero code while a
// prefix of that group is in force; code 0 means "none".
package pfx_pkg;

    localparam int NUM_GROUPS = 4;
    localparam int GCODE_W    = 3;
    localparam int GIDX_W     = 2;

    // Group index; the order matters because slots are addressed by it.
    typedef enum logic [GIDX_W-1:0] {
        GRP_LOCKREP = 2'd0,
        GRP_SEG     = 2'd1,
        GRP_OPSZ    = 2'd2,
        GRP_ADSZ    = 2'd3
    } grp_t;

    // Lock/repeat group code.
    typedef enum logic [1:0] {
        G1_NONE  = 2'd0,
        G1_LOCK  = 2'd1,
        G1_REPNE = 2'd2,
        G1_REPE  = 2'd3
    } g1_code_t;

    // Segment group code.
    typedef enum logic [2:0] {
        G2_NONE = 3'd0,
        G2_ES   = 3'd1,
        G2_CS   = 3'd2,
        G2_SS   = 3'd3,
        G2_DS   = 3'd4,
        G2_FS   = 3'd5,
        G2_GS   = 3'd6
    } g2_code_t;

endpackage

// File: rtl/pfx_classify.sv
// Module: pfx_classify
// Purely combinational. Decides whether a byte is one of the eleven prefix
// codes, names its group and gives the code to store in that group's slot.
// Assumes the caller ignores grp_o/code_o when is_pfx_o is low.
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [7:0]         byte_i,
    output logic               is_pfx_o,
    output grp_t               grp_o,
    output logic [GCODE_W-1:0] code_o
);

    // Map the byte onto prefix flag, group and per-group code.
    always_comb begin
        is_pfx_o = 1'b1;
        grp_o    = GRP_LOCKREP;
        code_o   = '0;
        case (byte_i)
            8'hF0: begin grp_o = GRP_LOCKREP; code_o = GCODE_W'(G1_LOCK);  end
            8'hF2: begin grp_o = GRP_LOCKREP; code_o = GCODE_W'(G1_REPNE); end
            8'hF3: begin grp_o = GRP_LOCKREP; code_o = GCODE_W'(G1_REPE);  end
            8'h26: begin grp_o = GRP_SEG;     code_o = G2_ES;              end
            8'h2E: begin grp_o = GRP_SEG;     code_o = G2_CS;              end
            8'h36: begin grp_o = GRP_SEG;     code_o = G2_SS;              end
            8'h3E: begin grp_o = GRP_SEG;     code_o = G2_DS;              end
            8'h64: begin grp_o = GRP_SEG;     code_o = G2_FS;              end
            8'h65: begin grp_o = GRP_SEG;     code_o = G2_GS;              end
            8'h66: begin grp_o = GRP_OPSZ;    code_o = GCODE_W'(1);        end
            8'h67: begin grp_o = GRP_ADSZ;    code_o = GCODE_W'(1);        end
            default: is_pfx_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfx_group_state.sv
// Module: pfx_group_state
// One slot per prefix group. A write replaces the addressed slot, so the last
// prefix of a group wins and a repeated override stays set. A clear empties
// every slot and takes priority over a write.
// Assumes wr_en and clr_i are qualified by the caller.
module pfx_group_state
    import pfx_pkg::*;
#(
    parameter int N_GRP  = NUM_GROUPS,
    parameter int CODE_W = GCODE_W,
    parameter int IDX_W  = GIDX_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [CODE_W-1:0]               wr_code,
    input  logic                            clr_i,
    output logic [N_GRP-1:0][CODE_W-1:0]    slot_q
);

    for (genvar g = 0; g < N_GRP; g++) begin : g_slot
        // Hold the code of the most recent prefix of group g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (clr_i) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_code;
            end
        end
    end

endmodule

// File: rtl/pfx_len_ctr.sv
// Module: pfx_len_ctr
// Counts prefix bytes of the current instruction. It reports a fault when the
// byte being taken would be prefix number MAX_LEN, because no opcode could
// then fit. The count returns to zero on an opcode or a fault.
// Assumes take_pfx and take_op are never high together.
module pfx_len_ctr #(
    parameter int MAX_LEN = 15,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_pfx,
    input  logic             take_op,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fault_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_LEN - 1);

    // Fault when the prefix being taken fills the whole length budget.
    assign fault_o = take_pfx && (cnt_q == LAST_CNT);

    // Advance on each prefix and restart at instruction boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take_op || fault_o) begin
            cnt_q <= '0;
        end else if (take_pfx) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/prefix_scanner.sv
// Module: prefix_scanner (top)
// Takes one instruction byte per cycle. Prefix bytes update the group slots.
// The first non-prefix byte produces a registered one-cycle result beat.
// A prefix run that reaches MAX_LEN produces a one-cycle fault and a reset of
// the state. Assumes the mode inputs are valid whenever an opcode byte is
// offered.
module prefix_scanner
    import pfx_pkg::*;
#(
    parameter int MAX_LEN = 15,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             mode_op32,
    input  logic             mode_ad32,
    output logic             out_valid,
    output logic             out_fault,
    output logic [1:0]       out_grp1,
    output logic [2:0]       out_grp2,
    output logic             out_opsz_ovr,
    output logic             out_adsz_ovr,
    output logic             out_op32,
    output logic             out_ad32,
    output logic [CNT_W-1:0] out_count,
    output logic [7:0]       out_opcode
);

    logic                                  is_pfx;
    grp_t                                  cls_grp;
    logic [GCODE_W-1:0]                    cls_code;
    logic                                  take_pfx;
    logic                                  take_op;
    logic                                  fault_now;
    logic [CNT_W-1:0]                      cnt_q;
    logic [NUM_GROUPS-1:0][GCODE_W-1:0]    slot_q;
    logic [1:0]                            st_g1;
    logic [2:0]                            st_g2;
    logic                                  st_opsz;
    logic                                  st_adsz;
    logic                                  unused_g1_msb;

    // The block never stalls the byte stream.
    assign in_ready = 1'b1;

    pfx_classify u_classify (
        .byte_i   (in_data),
        .is_pfx_o (is_pfx),
        .grp_o    (cls_grp),
        .code_o   (cls_code)
    );

    // Split the accepted byte into prefix and opcode events.
    assign take_pfx = in_valid && is_pfx;
    assign take_op  = in_valid && !is_pfx;

    pfx_len_ctr #(
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_pfx (take_pfx),
        .take_op  (take_op),
        .cnt_q    (cnt_q),
        .fault_o  (fault_now)
    );

    pfx_group_state #(
        .N_GRP  (NUM_GROUPS),
        .CODE_W (GCODE_W),
        .IDX_W  (GIDX_W)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_pfx),
        .wr_idx  (cls_grp),
        .wr_code (cls_code),
        .clr_i   (take_op || fault_now),
        .slot_q  (slot_q)
    );

    // Unpack the slots into the per-group fields.
    assign st_g1         = slot_q[GRP_LOCKREP][1:0];
    assign unused_g1_msb = slot_q[GRP_LOCKREP][GCODE_W-1];
    assign st_g2         = slot_q[GRP_SEG];
    assign st_opsz       = |slot_q[GRP_OPSZ];
    assign st_adsz       = |slot_q[GRP_ADSZ];

    // Pulse the result beat and the fault one cycle after the causing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
        end else begin
            out_valid <= take_op;
            out_fault <= fault_now;
        end
    end

    // Capture the resolved prefix fields when an opcode byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_grp1     <= '0;
            out_grp2     <= '0;
            out_opsz_ovr <= 1'b0;
            out_adsz_ovr <= 1'b0;
            out_op32     <= 1'b0;
            out_ad32     <= 1'b0;
            out_count    <= '0;
            out_opcode   <= '0;
        end else if (take_op) begin
            out_grp1     <= st_g1;
            out_grp2     <= st_g2;
            out_opsz_ovr <= st_opsz;
            out_adsz_ovr <= st_adsz;
            out_op32     <= mode_op32 ^ st_opsz;
            out_ad32     <= mode_ad32 ^ st_adsz;
            out_count    <= cnt_q;
            out_opcode   <= in_data;
        end
    end

endmodule

// File: rtl/prefix_scanner_chk.sv
// Module: prefix_scanner_chk
// Property checker for prefix_scanner, attached with bind. Observes ports and
// the unpacked group state of the top module.
module prefix_scanner_chk #(
    parameter int MAX_LEN = 15,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             mode_op32,
    input logic             mode_ad32,
    input logic             out_valid,
    input logic             out_fault,
    input logic             out_opsz_ovr,
    input logic             out_adsz_ovr,
    input logic             out_op32,
    input logic             out_ad32,
    input logic [CNT_W-1:0] out_count,
    input logic [7:0]       out_opcode,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       st_g1,
    input logic [2:0]       st_g2,
    input logic             st_opsz,
    input logic             st_adsz
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_LEN - 1);

    // R5: a repeat-equal byte replaces whatever lock/repeat prefix came before
    a_r5_last_wins_g1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == 8'hF3 && cnt_q != LAST_CNT) |=> (st_g1 == 2'd3));

    // R2: an FS override byte replaces any earlier segment prefix
    a_r2_seg_fs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == 8'h64 && cnt_q != LAST_CNT) |=> (st_g2 == 3'd5));

    // R6: a 66h byte always leaves the operand override set, never toggled
    a_r6_opsz_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == 8'h66 && cnt_q != LAST_CNT) |=> st_opsz);

    // R6: the same holds for 67h
    a_r6_adsz_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == 8'h67 && cnt_q != LAST_CNT) |=> st_adsz);

    // R7: effective sizes follow the sampled mode and the override flags
    a_r7_sizes: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_op32 == ($past(mode_op32) ^ out_opsz_ovr))
                   && (out_ad32 == ($past(mode_ad32) ^ out_adsz_ovr)));

    // R8: a result beat carries the byte taken one cycle earlier
    a_r8_beat_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && $past(in_data) == out_opcode
                       && out_count <= LAST_CNT));

    // R9: a fault only follows a prefix taken with the budget full
    a_r9_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> ($past(in_valid) && $past(cnt_q) == LAST_CNT));

    // R9: the result beat and the fault never coincide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault));

    // R10: state is empty whenever a beat or fault is shown
    a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_fault) |-> (st_g1 == 2'd0 && st_g2 == 3'd0
                                      && !st_opsz && !st_adsz && cnt_q == '0));

    // R11: without a valid byte no state moves
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(cnt_q) && $stable(st_g1) && $stable(st_g2)
                       && $stable(st_opsz) && $stable(st_adsz)));

endmodule

bind prefix_scanner prefix_scanner_chk #(
    .MAX_LEN (MAX_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .mode_op32    (mode_op32),
    .mode_ad32    (mode_ad32),
    .out_valid    (out_valid),
    .out_fault    (out_fault),
    .out_opsz_ovr (out_opsz_ovr),
    .out_adsz_ovr (out_adsz_ovr),
    .out_op32     (out_op32),
    .out_ad32     (out_ad32),
    .out_count    (out_count),
    .out_opcode   (out_opcode),
    .cnt_q        (cnt_q),
    .st_g1        (st_g1),
    .st_g2        (st_g2),
    .st_opsz      (st_opsz),
    .st_adsz      (st_adsz)
);

// File: tb/test_prefix_scanner.sv
`timescale 1ns/1ps
module test_prefix_scanner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       mode_op32 = 1'b1;
    logic       mode_ad32 = 1'b1;
    logic       out_valid, out_fault, out_opsz_ovr, out_adsz_ovr, out_op32, out_ad32;
    logic [1:0] out_grp1;
    logic [2:0] out_grp2;
    logic [3:0] out_count;
    logic [7:0] out_opcode;

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements.
    logic [1:0] m_g1;
    logic [2:0] m_g2;
    logic       m_o3, m_o4;
    int         m_cnt;

    logic [7:0] pfx_list [0:10] = '{8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                                    8'h26, 8'h64, 8'h65, 8'h66, 8'h67};

    always #2 clk = ~clk;

    prefix_scanner i_prefix_scanner (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mode_op32(mode_op32), .mode_ad32(mode_ad32),
        .out_valid(out_valid), .out_fault(out_fault), .out_grp1(out_grp1),
        .out_grp2(out_grp2), .out_opsz_ovr(out_opsz_ovr), .out_adsz_ovr(out_adsz_ovr),
        .out_op32(out_op32), .out_ad32(out_ad32), .out_count(out_count),
        .out_opcode(out_opcode)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Requirement tables R1, R2, R3: group (1..4, 0 = not a prefix) and code.
    function automatic void ref_class(input logic [7:0] b, output int grp, output int code);
        grp = 0; code = 0;
        case (b)
            8'hF0: begin grp = 1; code = 1; end
            8'hF2: begin grp = 1; code = 2; end
            8'hF3: begin grp = 1; code = 3; end
            8'h26: begin grp = 2; code = 1; end
            8'h2E: begin grp = 2; code = 2; end
            8'h36: begin grp = 2; code = 3; end
            8'h3E: begin grp = 2; code = 4; end
            8'h64: begin grp = 2; code = 5; end
            8'h65: begin grp = 2; code = 6; end
            8'h66: begin grp = 3; code = 1; end
            8'h67: begin grp = 4; code = 1; end
            default: ;
        endcase
    endfunction

    task automatic model_clear();
        m_g1 = 0; m_g2 = 0; m_o3 = 0; m_o4 = 0; m_cnt = 0;
    endtask

    // Offer one byte, let it be taken, then compare the outputs of that edge.
    task automatic step(input logic [7:0] b, input string tag);
        int grp, code;
        logic [31:0] act, exp;
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        ref_class(b, grp, code);
        if (grp != 0) begin
            m_cnt++;
            if (m_cnt == 15) begin
                act = {30'd0, out_valid, out_fault};
                check(act == 32'd1, {tag, " R9 fault"}, act, 32'd1);
                model_clear();
            end else begin
                case (grp)
                    1: m_g1 = 2'(code);
                    2: m_g2 = 3'(code);
                    3: m_o3 = 1'b1;
                    default: m_o4 = 1'b1;
                endcase
                act = {30'd0, out_valid, out_fault};
                check(act == 32'd0, {tag, " R8 quiet on prefix"}, act, 32'd0);
            end
        end else begin
            exp = {6'd0, 1'b1, 1'b0, m_g1, m_g2, m_o3, m_o4,
                   mode_op32 ^ m_o3, mode_ad32 ^ m_o4, 4'(m_cnt), b};
            act = {6'd0, out_valid, out_fault, out_grp1, out_grp2, out_opsz_ovr,
                   out_adsz_ovr, out_op32, out_ad32, out_count, out_opcode};
            check(act == exp, {tag, " R8 result"}, act, exp);
            model_clear();
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: state after reset and ready level.
        check({out_valid, out_fault, out_count} == 6'd0, "R11 reset outputs",
              {26'd0, out_valid, out_fault, out_count}, 32'd0);
        check(in_ready == 1'b1, "R11 ready high", {31'd0, in_ready}, 32'd1);

        // R1 R2 R3: every byte value, alone or followed by an opcode.
        for (int b = 0; b < 256; b++) begin
            int grp, code;
            ref_class(8'(b), grp, code);
            if (grp == 1) begin step(8'(b), "R1"); step(8'h90, "R1"); end
            else if (grp == 2) begin step(8'(b), "R2"); step(8'hA4, "R2"); end
            else if (grp != 0) begin step(8'(b), "R3"); step(8'h8B, "R3"); end
            else step(8'(b), "R3 opcode");
        end

        // R4 R5 R6: every ordered pair of prefixes, then an opcode.
        for (int i = 0; i < 11; i++) begin
            for (int j = 0; j < 11; j++) begin
                int gi, gj, c;
                ref_class(pfx_list[i], gi, c);
                ref_class(pfx_list[j], gj, c);
                if (gi != gj) begin
                    step(pfx_list[i], "R4"); step(pfx_list[j], "R4"); step(8'hA6, "R4");
                end else if (gi >= 3) begin
                    step(pfx_list[i], "R6"); step(pfx_list[j], "R6");
                    step(pfx_list[j], "R6"); step(8'hA6, "R6");
                end else begin
                    step(pfx_list[i], "R5"); step(pfx_list[j], "R5"); step(8'hA6, "R5");
                end
            end
        end

        // R7: every default mode against every override combination.
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 4; o++) begin
                mode_op32 = m[0];
                mode_ad32 = m[1];
                if (o[0]) step(8'h66, "R7");
                if (o[1]) step(8'h67, "R7");
                step(8'h01, "R7");
            end
        end
        mode_op32 = 1'b1;
        mode_ad32 = 1'b0;

        // R11: idle cycles inside an instruction change nothing.
        step(8'hF2, "R11");
        repeat (3) begin
            @(posedge clk); #1;
            check({out_valid, out_fault} == 2'b00, "R11 idle quiet",
                  {30'd0, out_valid, out_fault}, 32'd0);
        end
        step(8'h3E, "R11");
        repeat (2) @(posedge clk);
        #1;
        step(8'hAE, "R11");

        // R9 R10: prefix runs of every length up to two past the limit.
        for (int n = 0; n <= 17; n++) begin
            for (int k = 0; k < n; k++) step(pfx_list[(k + n) % 11], "R9");
            step(8'hC3, "R10");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule